// File: doc/BRIEF.md
# Scalar Bit Walker

This block takes a 32-bit scalar, such as the multiplier of a double-and-add or square-and-multiply loop, and emits its bits one per clock. It begins at the highest set bit and ends at bit 0, so the number of steps equals the real bit length of the scalar and not the width of the word. The arithmetic unit that consumes the bits sits outside this block. That unit learns from the first-bit flag when the walk begins and from the done pulse when it ends.

A scalar is offered with `op_valid` and is taken on a clock edge where `op_ready` is also high. In the cycle of acceptance a combinational search finds the most significant set bit. A marker register is loaded with a single 1 at that position. The marker moves down one place per emitted bit, and the walk ends once the marker has left bit 0. The consumer applies back-pressure with `hold`: while `hold` is high no bit is emitted and both the scalar and the marker stay frozen. The same bit is then presented again once `hold` falls. A scalar of zero produces no bits and only a done pulse.

Top module: `scalar_bit_walker`

## Requirements
- R1: After a synchronous active-high reset, `op_ready` is 1, and `bit_valid`, `bit_first` and `done` are 0.
- R2: A scalar is accepted only on a rising edge where both `op_valid` and `op_ready` are 1. `bit_valid` is never 1 while `op_ready` is 1.
- R3: For a nonzero scalar, `bit_valid` is high for exactly floor(log2(scalar))+1 cycles, not counting cycles in which `hold` is high.
- R4: The bits are presented on `bit_out` from the highest set bit down to bit 0. For example, the scalar 17 gives 1,0,0,0,1.
- R5: `bit_first` is 1 only in the first cycle with `bit_valid` high for each scalar, and never outside a valid cycle.
- R6: A scalar of zero produces no valid cycle. `done` is 1 in the first cycle after the acceptance edge.
- R7: `done` is high for exactly one cycle, in the cycle right after the last valid bit.
- R8: `op_ready` is 0 from the cycle after acceptance through the done cycle, and it is 1 again in the cycle after `done`.
- R9: While `hold` is 1 during a walk, `bit_valid` is 0 and the pending bit is not lost. The stream resumes with the same bit once `hold` is 0.
- R10: Changes on `op_word` and `op_valid` while the block is busy have no effect on the bit sequence being emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Scalar offered on op_word |
| op_ready | output | 1 | Block can accept a scalar |
| op_word | input | 32 | Scalar to walk |
| hold | input | 1 | Consumer stall; freezes the walk |
| bit_out | output | 1 | Current scalar bit |
| bit_valid | output | 1 | bit_out is a step of the walk |
| bit_first | output | 1 | This step is the first one (highest set bit) |
| done | output | 1 | One-cycle pulse marking the end of the walk |

## Verification
The walk is tried on 17, whose bit order and length are known exactly. It is also tried on 1 and 0x80000000, which probe the shortest and longest walks and the marker's two end positions, and on zero, which must skip the walk entirely. An all-ones scalar separates a correct length from a stream that stops early or late. A sparse scalar under a periodic `hold` shows whether a stall drops or repeats a bit. Pokes at `op_valid` with new scalars during a walk show that a busy block ignores them, and back-to-back walks confirm that `op_ready` comes back at the right cycle.

// File: rtl/bitwalk_pkg.sv
package bitwalk_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_RUN  = 2'd1,
    WALK_FIN  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/bw_msb_onehot.sv
module bw_msb_onehot #(
  parameter int W = 32
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] onehot,
  output logic         any_set
);
  // Scan from the top; keep only the first 1 met.
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      onehot[i] = vec[i] & ~seen;
      seen      = seen | vec[i];
    end
    any_set = seen;
  end

  always_comb begin
    if (!$isunknown(vec)) begin
      AST_LOCATE_ONEHOT: assert ($onehot0(onehot) && ((onehot != '0) == (vec != '0))); // R3
    end
  end
endmodule

// File: rtl/bw_step_regs.sv
module bw_step_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic [W-1:0] load_mark,
  input  logic         step,
  output logic         cur_bit,
  output logic         at_last,
  output logic         first
);
  logic [W-1:0] data_q;
  logic [W-1:0] mark_q;
  logic         first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      mark_q  <= '0;
      first_q <= 1'b0;
    end else if (load) begin
      data_q  <= load_data;
      mark_q  <= load_mark;
      first_q <= |load_mark;
    end else if (step) begin
      mark_q  <= mark_q >> 1;
      first_q <= 1'b0;
    end
  end

  assign cur_bit = |(data_q & mark_q);
  assign at_last = mark_q[0];
  assign first   = first_q;

  AST_MARK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mark_q)); // R3
endmodule

// File: rtl/bw_walk_ctrl.sv
module bw_walk_ctrl
  import bitwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        any_set,
  input  logic        hold,
  input  logic        at_last,
  output walk_state_e state,
  output logic        load,
  output logic        ready,
  output logic        done
);
  walk_state_e st_q, st_d;

  assign ready = (st_q == WALK_IDLE);
  assign load  = ready & req_valid;
  assign done  = (st_q == WALK_FIN);
  assign state = st_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      WALK_IDLE: if (req_valid) st_d = any_set ? WALK_RUN : WALK_FIN;
      WALK_RUN:  if (!hold && at_last) st_d = WALK_FIN;
      WALK_FIN:  st_d = WALK_IDLE;
      default:   st_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= WALK_IDLE;
    else     st_q <= st_d;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> ready); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    load |=> !ready); // R8
  AST_ZERO_SKIPS: assert property (@(posedge clk) disable iff (rst)
    (load && !any_set) |=> done); // R6
endmodule

// File: rtl/scalar_bit_walker.sv
module scalar_bit_walker
  import bitwalk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [W-1:0] op_word,
  input  logic         hold,
  output logic         bit_out,
  output logic         bit_valid,
  output logic         bit_first,
  output logic         done
);
  logic [W-1:0] start_mark;
  logic         any_set;
  logic         load;
  logic         step;
  logic         at_last;
  logic         first_q;
  logic         cur_bit;
  walk_state_e  state;

  bw_msb_onehot #(.W(W)) u_locate (
    .vec     (op_word),
    .onehot  (start_mark),
    .any_set (any_set)
  );

  bw_walk_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (op_valid),
    .any_set   (any_set),
    .hold      (hold),
    .at_last   (at_last),
    .state     (state),
    .load      (load),
    .ready     (op_ready),
    .done      (done)
  );

  assign step = (state == WALK_RUN) && !hold;

  bw_step_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (op_word),
    .load_mark (start_mark),
    .step      (step),
    .cur_bit   (cur_bit),
    .at_last   (at_last),
    .first     (first_q)
  );

  assign bit_valid = step;
  assign bit_out   = cur_bit;
  assign bit_first = step & first_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    op_ready |-> !bit_valid); // R2
  AST_FIRST_IN_BEAT: assert property (@(posedge clk) disable iff (rst)
    bit_first |-> bit_valid); // R5
  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_first); // R5
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (state == WALK_RUN && hold) |=> (state == WALK_RUN && $stable(bit_out))); // R9
endmodule

// File: tb/tb_scalar_bit_walker.sv
module tb_scalar_bit_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [31:0] op_word = '0;
  logic        hold = 1'b0;
  logic        op_ready, bit_out, bit_valid, bit_first, done;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scalar_bit_walker dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_word(op_word), .hold(hold), .bit_out(bit_out),
    .bit_valid(bit_valid), .bit_first(bit_first), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bit_len(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return i + 1;
    return 0;
  endfunction

  // Walk one scalar; hold_mode stalls every third cycle, poke drives junk starts.
  task automatic walk(input logic [31:0] v, input bit hold_mode, input bit poke);
    int len, nbeat, nfirst, last_beat, done_at, cyc;
    bit order_ok, hold_ok, ready_ok, first_ok;
    len = bit_len(v);
    nbeat = 0; nfirst = 0; last_beat = -1; done_at = -1;
    order_ok = 1; hold_ok = 1; ready_ok = 1; first_ok = 1;
    @(negedge clk);
    op_valid = 1'b1; op_word = v; hold = 1'b0;
    #1;
    check(op_ready == 1'b1, "R8", "ready before accept", op_ready, 1);
    @(posedge clk);
    for (cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk);
      op_valid = poke;
      op_word  = ~v ^ (cyc * 32'h9E37_79B9);  // R10 junk while busy
      hold     = hold_mode && (cyc % 3 == 1);
      #1;
      if (hold && bit_valid) hold_ok = 0;
      if (bit_valid) begin
        if (nbeat < len) begin
          if (bit_out !== v[len - 1 - nbeat]) order_ok = 0;
        end
        if (bit_first) begin
          nfirst++;
          if (nbeat != 0) first_ok = 0;
        end
        nbeat++;
        last_beat = cyc;
      end else if (bit_first) first_ok = 0;
      if (done) begin
        done_at = cyc;
        if (op_ready) ready_ok = 0;
        break;
      end
      if (op_ready) ready_ok = 0;
    end
    @(negedge clk);
    op_valid = 1'b0; hold = 1'b0;
    #1;
    check(nbeat == len, "R3", "beat count", nbeat, len);
    check(order_ok, "R4", "bit order", order_ok, 1);
    if (len == 0) begin
      check(done_at == 0, "R6", "zero done cycle", done_at, 0);
    end else begin
      check(nfirst == 1 && first_ok, "R5", "first flag", nfirst, 1);
      check(done_at == last_beat + 1, "R7", "done after last bit", done_at, last_beat + 1);
    end
    check(ready_ok, "R8", "ready low while busy", ready_ok, 1);
    check(op_ready == 1'b1 && done == 1'b0, "R8", "ready after done", op_ready, 1);
    check(done == 1'b0, "R7", "done one cycle", done, 0);
    if (hold_mode) check(hold_ok, "R9", "no beat under hold", hold_ok, 1);
    if (poke) check(order_ok && nbeat == len, "R10", "busy start ignored", nbeat, len);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(op_ready == 1'b1, "R1", "reset ready", op_ready, 1);
    check(bit_valid == 1'b0 && bit_first == 1'b0, "R1", "reset valid", bit_valid, 0);
    check(done == 1'b0, "R1", "reset done", done, 0);
  endtask

  task automatic test_no_request;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op_word = 32'hFFFF_0000; op_valid = 1'b0;
      #1;
      check(op_ready && !bit_valid && !done, "R2", "no walk without op_valid", bit_valid, 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_no_request();
    walk(32'd17, 0, 0);
    walk(32'd0, 0, 0);
    walk(32'd1, 0, 0);
    walk(32'h8000_0000, 0, 0);
    walk(32'hFFFF_FFFF, 0, 0);
    walk(32'h00A5_0000, 1, 0);
    walk(32'd17, 1, 1);
    walk(32'h0000_0C03, 0, 1);
    walk(32'd0, 1, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule